// File: doc/BRIEF.md
# Chained Two-Bit Operation Unit

This block is a small operation unit for short arithmetic and logic chains. A two-bit select picks one of four fixed operations: complement, AND, OR or add. The operations act on an external first operand and on a second operand. The result appears combinationally on the outputs in the same cycle.

A register inside the block holds the second operand. On every rising clock edge it captures the current result. When the load control is high, the external second-operand input takes the register's place for that step. A chain therefore starts with one loaded step, and each later step works on the result of the step before. The select may change on every step.

The datapath width is a parameter, with a default of two bits.

Top module: `fa_chain_unit`

## Requirements
- R1: After a synchronous active-high reset, the operand register holds zero. The first step that follows with load low uses zero as the second operand.
- R2: Select code 2'b11 outputs the bitwise complement of the second operand. The first operand has no effect on the output.
- R3: Select code 2'b10 outputs the bitwise AND of the first and second operands.
- R4: Select code 2'b01 outputs the bitwise OR of the first and second operands.
- R5: Select code 2'b00 outputs the unsigned sum of the two operands. The result port carries the low WIDTH bits and the carry port carries the carry-out bit.
- R6: For every select code other than 2'b00, the carry port is 0.
- R7: While load is 1, the second operand is the external operand input, and the register contents have no effect on the output.
- R8: While load is 0, the second operand is the result that was on the result port at the previous rising clock edge.
- R9: The select code may differ on each step. A chain of mixed operations produces the results of applying each operation in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the operand register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation select code |
| a_in | input | WIDTH | First operand |
| c_in | input | WIDTH | External second operand, used while load is high |
| load | input | 1 | 1 selects c_in as the second operand; 0 selects the registered result |
| res | output | WIDTH | Operation result |
| carry | output | 1 | Carry-out of the add; 0 for the other operations |

## Verification
The bench builds the block with the default WIDTH of 2. At this width, every select code can be driven with all sixteen combinations of the two operands, so each operation's truth table is covered completely, including the add's carry-out at 3+3. Chained runs then load the operand once and change the select at every step. These runs exercise the feedback path and show that, with load low, the external operand input is ignored.

// File: rtl/fa_pkg.sv
package fa_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_OR  = 2'b01,
      OP_AND = 2'b10,
      OP_INV = 2'b11
   } fa_op_e;
endpackage

// File: rtl/fa_operand_mux.sv
module fa_operand_mux #(
   parameter int WIDTH = 2
) (
   input  logic             load,
   input  logic [WIDTH-1:0] ext_op,
   input  logic [WIDTH-1:0] fb_op,
   output logic [WIDTH-1:0] op_out
);
   initial begin
      if (WIDTH < 1) $error("fa_operand_mux: WIDTH must be at least 1");
   end

   // Per-bit select between the external operand and the feedback value
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign op_out[i] = load ? ext_op[i] : fb_op[i];
   end
endmodule

// File: rtl/fa_bitwise.sv
module fa_bitwise #(
   parameter int WIDTH = 2
) (
   input  fa_pkg::fa_op_e   op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   import fa_pkg::*;

   initial begin
      if (WIDTH < 1) $error("fa_bitwise: WIDTH must be at least 1");
   end

   // One logic cell per bit; the add code is handled by the adder
   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      always_comb begin
         unique case (op)
            OP_INV:  y[i] = ~b[i];
            OP_AND:  y[i] = a[i] & b[i];
            OP_OR:   y[i] = a[i] | b[i];
            default: y[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/fa_adder.sv
module fa_adder #(
   parameter int WIDTH = 2
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   initial begin
      if (WIDTH < 1) $error("fa_adder: WIDTH must be at least 1");
   end

   logic [WIDTH:0] cy;
   assign cy[0] = 1'b0;

   // Ripple chain of full adders
   for (genvar i = 0; i < WIDTH; i++) begin : g_fa
      assign sum[i]   = a[i] ^ b[i] ^ cy[i];
      assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
   end

   assign cout = cy[WIDTH];
endmodule

// File: rtl/fa_op_reg.sv
module fa_op_reg #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1) $error("fa_op_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

   // R8: the register holds what was presented on the previous edge
   p_capture_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> q == $past(d));
endmodule

// File: rtl/fa_chain_unit.sv
module fa_chain_unit #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op_sel,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] c_in,
   input  logic             load,
   output logic [WIDTH-1:0] res,
   output logic             carry
);
   import fa_pkg::*;

   localparam int MAX_WIDTH = 32;

   initial begin
      if (WIDTH < 1 || WIDTH > MAX_WIDTH)
         $error("fa_chain_unit: WIDTH %0d out of range", WIDTH);
   end

   fa_op_e           op;
   logic [WIDTH-1:0] acc_q;
   logic [WIDTH-1:0] operand;
   logic [WIDTH-1:0] bw_y;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;

   assign op = fa_op_e'(op_sel);

   fa_operand_mux #(.WIDTH(WIDTH)) u_mux (
      .load   (load),
      .ext_op (c_in),
      .fb_op  (acc_q),
      .op_out (operand)
   );

   fa_bitwise #(.WIDTH(WIDTH)) u_bw (
      .op (op),
      .a  (a_in),
      .b  (operand),
      .y  (bw_y)
   );

   fa_adder #(.WIDTH(WIDTH)) u_add (
      .a    (a_in),
      .b    (operand),
      .sum  (add_sum),
      .cout (add_cout)
   );

   // Result select: the carry bit is driven only by the add
   always_comb begin
      if (op == OP_ADD) begin
         res   = add_sum;
         carry = add_cout;
      end else begin
         res   = bw_y;
         carry = 1'b0;
      end
   end

   fa_op_reg #(.WIDTH(WIDTH)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (res),
      .q   (acc_q)
   );

   // R1: the first step after reset sees a zero operand
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !load && op_sel == 2'b01 && a_in == '0) |-> res == '0);

   // R2: complement of the loaded operand
   p_invert_r2: assert property (@(posedge clk) disable iff (rst)
      (load && op_sel == 2'b11) |-> res == ~c_in);

   // R5: add of the loaded operand
   p_sum_r5: assert property (@(posedge clk) disable iff (rst)
      (load && op_sel == 2'b00) |-> {carry, res} == ({1'b0, a_in} + {1'b0, c_in}));

   // R6: no carry outside the add
   p_carry_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      (op_sel != 2'b00) |-> !carry);

   // R7: a loaded OR with zero passes the external operand through
   p_load_pass_r7: assert property (@(posedge clk) disable iff (rst)
      (load && op_sel == 2'b01 && a_in == '0) |-> res == c_in);
endmodule

// File: tb/sim_fa_chain_unit.sv
module sim_fa_chain_unit;
   localparam int W = 2;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   op_sel = 2'b00;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] c_in = '0;
   logic         load = 1'b0;
   logic [W-1:0] res;
   logic         carry;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit    valid;
      int    exp_res;
      int    exp_carry;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   model_acc = 0;

   always #10 clk = ~clk;   // 50 MHz

   fa_chain_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .op_sel(op_sel), .a_in(a_in),
      .c_in(c_in), .load(load), .res(res), .carry(carry)
   );

   // Driver: applies one step per cycle and pushes the expected values
   task automatic step(input logic [1:0] s, input int a, input int c,
                       input bit ld, input bit do_rst, input string tag);
      exp_t e;
      int opnd;
      int r;
      int cy;
      @(negedge clk);
      rst = do_rst; op_sel = s; a_in = W'(a); c_in = W'(c); load = ld;
      opnd = ld ? c : model_acc;
      cy = 0;
      case (s)
         2'b11: r = (~opnd) & MASK;
         2'b10: r = a & opnd;
         2'b01: r = a | opnd;
         default: begin r = (a + opnd) & MASK; cy = ((a + opnd) >> W) & 1; end
      endcase
      e.valid = !do_rst;
      e.exp_res = r;
      e.exp_carry = cy;
      e.tag = tag;
      sb.push_back(e);
      model_acc = do_rst ? 0 : r;
   endtask

   // Monitor: compares 5 ns ahead of the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.valid) begin
               checks++;
               if (int'(res) != e.exp_res) begin
                  errors++;
                  $display("FAIL %s res: actual %0d expected %0d", e.tag, res, e.exp_res);
               end
               checks++;
               if (int'(carry) != e.exp_carry) begin
                  errors++;
                  $display("FAIL %s carry: actual %0d expected %0d", e.tag, carry, e.exp_carry);
               end
            end
         end
      end
   end

   function automatic string op_tag(input logic [1:0] s);
      case (s)
         2'b11: return "R2 R6 R7";
         2'b10: return "R3 R6 R7";
         2'b01: return "R4 R6 R7";
         default: return "R5 R7";
      endcase
   endfunction

   initial begin
      // R1: reset, then a step with load low must see a zero operand
      step(2'b01, 0, 3, 1'b1, 1'b1, "reset");
      step(2'b01, 0, 3, 1'b1, 1'b1, "reset");
      step(2'b01, 0, 3, 1'b0, 1'b0, "R1");
      step(2'b00, 1, 3, 1'b0, 1'b0, "R1 R8");
      // R2..R7: every code, all operand pairs, loaded operand
      for (int s = 0; s < 4; s++)
         for (int a = 0; a <= MASK; a++)
            for (int c = 0; c <= MASK; c++)
               step(2'(s), a, c, 1'b1, 1'b0, op_tag(2'(s)));
      // R8/R9: chains with one loaded step and the select changing each step
      step(2'b01, 0, 2, 1'b1, 1'b0, "R7 chain");
      step(2'b00, 1, 0, 1'b0, 1'b0, "R8 R9");
      step(2'b11, 2, 1, 1'b0, 1'b0, "R8 R9 R2");
      step(2'b10, 3, 3, 1'b0, 1'b0, "R8 R9 R3");
      step(2'b01, 2, 0, 1'b0, 1'b0, "R8 R9 R4");
      step(2'b00, 3, 2, 1'b0, 1'b0, "R8 R9 R5");
      step(2'b00, 3, 1, 1'b0, 1'b0, "R8 R9 R5");
      step(2'b11, 0, 3, 1'b1, 1'b0, "R7 chain2");
      step(2'b11, 1, 0, 1'b0, 1'b0, "R8 R9 R2");
      step(2'b10, 2, 1, 1'b0, 1'b0, "R8 R9 R3");
      step(2'b00, 3, 3, 1'b0, 1'b0, "R8 R9 R5");
      // A reset in the middle of a chain clears the operand (R1)
      step(2'b00, 0, 0, 1'b0, 1'b1, "reset");
      step(2'b00, 2, 3, 1'b0, 1'b0, "R1 R8");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule